// File: doc/BRIEF.md
# Interrupt Source Selector and Pin Qualifier

This block sits in front of a CPU interrupt controller and decides which of sixteen event sources drives each of the twelve maskable CPU interrupt lines, INT4 through INT15. Each line has its own 4-bit select code. Two 32-bit map registers hold the codes, six per register. Every line can pick any source, so one source can drive several lines and a source can also be left unused.

Twelve of the sources are internal single-cycle event pulses from on-chip peripherals. The other four are external, active-low interrupt pins. These pins first pass through a two-flop synchronizer. A qualifier then accepts an event only after the synchronized pin has been low for a minimum time and then high for a minimum time. The qualified event is latched, and a registered output stage presents it as a one-cycle pulse on every CPU line that selects it.

Software writes a whole map register through a simple write strobe with a register select. The selected register reads back combinationally.

Top module: `irq_route_top`

## Requirements
- R1: Source codes are fixed as follows. Codes 4 to 7 are external pins 0 to 3 (`ext_pin_i[c-4]`). Codes 0 to 3 are `periph_evt_i[3:0]`, carrying host port, timer 0, timer 1 and memory refresh. Codes 8 to 15 are `periph_evt_i[11:4]`, carrying DMA channels 0 to 3, then serial port 0 transmit and receive, then serial port 1 transmit and receive.
- R2: `reg_sel_i`=0 addresses the high map register, which holds the selects for INT10..INT15. `reg_sel_i`=1 addresses the low map register, which holds the selects for INT4..INT9. In each register, the fields for ascending line numbers start at bits 0, 5, 10, 16, 21 and 26, and each field is 4 bits wide. A write replaces all six fields. `reg_rdata_o` shows the addressed register.
- R3: Register bits outside the twelve select fields always read 0, and writes to them have no effect.
- R4: After reset, `cpu_int_o` is 0 and line INTn (output bit n-4) selects code n-4. The low register therefore reads fields 0..5 and the high register reads fields 6..11.
- R5: A pulse on an internal source appears on every line selecting it exactly one clock later, with `cpu_int_o[k]` = source[sel_k] of the previous cycle.
- R6: A pin that is low for at least 2 cycles and then high for at least 2 cycles gives exactly one pulse. The pulse is seen 5 cycles after the cycle in which the pin rose: two synchronizer flops, two high samples (the second of which latches the event), and the output register.
- R7: A low time of 1 cycle gives no event. A high time of 1 cycle after a valid low gives no event, the low qualification is kept, and a later high of 2 cycles or more still fires once.
- R8: A new select code applies from the cycle after the write. An event in the same cycle as the write is routed by the old code.
- R9: Several lines selecting one source all pulse together. A line whose selected source is quiet stays low.
- R10: Every qualified pin event is a single-cycle pulse, even while the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Map register write strobe |
| reg_sel_i | input | 1 | 0 = high map (INT10..15), 1 = low map (INT4..9) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Addressed map register contents |
| periph_evt_i | input | 12 | Internal event pulses for codes 0..3 and 8..15 |
| ext_pin_i | input | 4 | Asynchronous active-low external interrupt pins |
| cpu_int_o | output | 12 | Interrupt pulses, bit k drives INT(k+4) |

## Verification
A map register write and a source event can land in the same clock cycle. In that case the event must follow the code that was in place before the write. A directed case writes a new code to INT4 while its old source pulses, and expects the pulse on INT4. It then pulses the new source and the old source in turn, and expects only the new one to reach INT4. The random phase also issues writes together with random event pulses, and judges every cycle against a bench model of the map that is updated only after the expected outputs have been computed.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NUM_LINES = 12;
  localparam int NUM_SRC   = 16;
  localparam int SEL_W     = 4;
  localparam int FPR       = 6;   // fields per map register
  localparam int NUM_EXT   = 4;
  localparam int EXT_BASE  = 4;   // first source code owned by pins
  localparam int REG_W     = 32;

  // irregular field layout: one spare bit after every field except before bit 16
  function automatic int field_lsb(int f);
    return f * (SEL_W + 1) + ((f >= FPR / 2) ? 1 : 0);
  endfunction

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int f = 0; f < FPR; f++) m[field_lsb(f) +: SEL_W] = '1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] FIELD_MASK = field_mask();
endpackage

// File: rtl/irq_pin_qual.sv
module irq_pin_qual #(
  parameter int LOW_MIN  = 2,
  parameter int HIGH_MIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o,
  output logic evt_o
);
  localparam int MAXC = (LOW_MIN > HIGH_MIN) ? LOW_MIN : HIGH_MIN;
  localparam int CW   = $clog2(MAXC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] low_cnt, hi_cnt;
  logic          armed, evt_q;
  logic          s;

  assign s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      low_cnt <= '0;
      hi_cnt  <= '0;
      armed   <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      evt_q  <= 1'b0;
      if (!s) begin
        hi_cnt <= '0;
        if (low_cnt != CW'(LOW_MIN)) low_cnt <= low_cnt + 1'b1;
        if (low_cnt == CW'(LOW_MIN - 1)) armed <= 1'b1;
      end else begin
        low_cnt <= '0;
        if (armed) begin
          if (hi_cnt == CW'(HIGH_MIN - 1)) begin
            evt_q  <= 1'b1;       // latch point
            armed  <= 1'b0;
            hi_cnt <= '0;
          end else begin
            hi_cnt <= hi_cnt + 1'b1;
          end
        end else begin
          hi_cnt <= '0;
        end
      end
    end
  end

  assign sync_o = s;
  assign evt_o  = evt_q;
endmodule

// File: rtl/irq_map_regs.sv
module irq_map_regs
  import irq_route_pkg::*;
#(
  parameter int LINES = NUM_LINES,
  parameter int SW    = SEL_W,
  parameter int PER   = FPR
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     sel_i,
  input  logic [REG_W-1:0]         wdata_i,
  output logic [REG_W-1:0]         rdata_o,
  output logic [LINES-1:0][SW-1:0] line_sel_o
);
  logic [LINES-1:0][SW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < LINES; k++) sel_q[k] <= SW'(k);
    end else if (we_i) begin
      for (int k = 0; k < LINES; k++) begin
        // lines below PER live in the low register (sel_i = 1)
        if ((k < PER) ? sel_i : !sel_i)
          sel_q[k] <= wdata_i[field_lsb(k % PER) +: SW];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int f = 0; f < PER; f++)
      rdata_o[field_lsb(f) +: SW] = sel_i ? sel_q[f] : sel_q[f + PER];
  end

  assign line_sel_o = sel_q;
endmodule

// File: rtl/irq_route_xbar.sv
module irq_route_xbar #(
  parameter int SRCS  = 16,
  parameter int LINES = 12,
  parameter int SW    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SRCS-1:0]          src_i,
  input  logic [LINES-1:0][SW-1:0] line_sel_i,
  output logic [LINES-1:0]         line_o
);
  logic [LINES-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else for (int k = 0; k < LINES; k++) line_q[k] <= src_i[line_sel_i[k]];
  end

  assign line_o = line_q;
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic                       reg_sel_i,
  input  logic [REG_W-1:0]           reg_wdata_i,
  output logic [REG_W-1:0]           reg_rdata_o,
  input  logic [NUM_SRC-NUM_EXT-1:0] periph_evt_i,
  input  logic [NUM_EXT-1:0]         ext_pin_i,
  output logic [NUM_LINES-1:0]       cpu_int_o
);
  logic [NUM_EXT-1:0]                 ext_sync, ext_evt;
  logic [NUM_SRC-1:0]                 src_vec;
  logic [NUM_LINES-1:0][SEL_W-1:0]    line_sel;
  logic [NUM_LINES*SEL_W-1:0]         line_sel_flat;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
    irq_pin_qual #(.LOW_MIN(2), .HIGH_MIN(2)) u_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ext_pin_i[i]),
      .sync_o(ext_sync[i]),
      .evt_o (ext_evt[i])
    );
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < EXT_BASE) begin : g_lo
      assign src_vec[s] = periph_evt_i[s];
    end else if (s < EXT_BASE + NUM_EXT) begin : g_ext
      assign src_vec[s] = ext_evt[s - EXT_BASE];
    end else begin : g_hi
      assign src_vec[s] = periph_evt_i[s - NUM_EXT];
    end
  end

  irq_map_regs u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .line_sel_o(line_sel)
  );

  assign line_sel_flat = line_sel;

  irq_route_xbar #(.SRCS(NUM_SRC), .LINES(NUM_LINES), .SW(SEL_W)) u_xbar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src_vec),
    .line_sel_i(line_sel),
    .line_o    (cpu_int_o)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       reg_we_i,
  input logic                       reg_sel_i,
  input logic [REG_W-1:0]           reg_wdata_i,
  input logic [REG_W-1:0]           reg_rdata_o,
  input logic [NUM_SRC-1:0]         src_vec,
  input logic [NUM_LINES*SEL_W-1:0] line_sel,
  input logic [NUM_EXT-1:0]         ext_sync,
  input logic [NUM_EXT-1:0]         ext_evt,
  input logic [NUM_LINES-1:0]       cpu_int_o
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~FIELD_MASK) == '0);

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> (reg_sel_i != $past(reg_sel_i)) ||
                 (reg_rdata_o == ($past(reg_wdata_i) & FIELD_MASK)));

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    p_route_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      started_q |-> cpu_int_o[k] == $past(src_vec[line_sel[k*SEL_W +: SEL_W]]));
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    p_high_before_evt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_evt[i] |-> $past(ext_sync[i]) && $past(ext_sync[i], 2));
    p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_evt[i] |=> !ext_evt[i]);
  end
endmodule

bind irq_route_top irq_route_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .src_vec    (src_vec),
  .line_sel   (line_sel_flat),
  .ext_sync   (ext_sync),
  .ext_evt    (ext_evt),
  .cpu_int_o  (cpu_int_o)
);

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] periph = '0;
  logic [3:0]  pins = 4'hF;
  logic [11:0] cpu_int;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] model_lo, model_hi;
  int cyc = 0, pulses = 0, last_pulse = 0;

  always #5 clk = ~clk;

  irq_route_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .periph_evt_i(periph),
    .ext_pin_i(pins), .cpu_int_o(cpu_int)
  );

  function automatic int lsb_of(int f);
    return f * 5 + ((f >= 3) ? 1 : 0);
  endfunction

  function automatic logic [31:0] mask32();
    logic [31:0] m = '0;
    for (int f = 0; f < 6; f++) m[lsb_of(f) +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [31:0] pack6(int base);
    logic [31:0] r = '0;
    for (int f = 0; f < 6; f++) r[lsb_of(f) +: 4] = 4'(base + f);
    return r;
  endfunction

  function automatic logic [3:0] sel_of(int k);
    return (k < 6) ? model_lo[lsb_of(k) +: 4] : model_hi[lsb_of(k - 6) +: 4];
  endfunction

  function automatic logic [15:0] src_of(logic [11:0] p);
    return {p[11:4], 4'b0000, p[3:0]};
  endfunction

  function automatic logic [11:0] exp_lines(logic [15:0] s);
    logic [11:0] e;
    for (int k = 0; k < 12; k++) e[k] = s[sel_of(k)];
    return e;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(bit sel, logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel) model_lo = d & mask32(); else model_hi = d & mask32();
  endtask

  // set pin line, hold n cycles, watch line k each cycle
  task automatic drive_pin(int idx, bit v, int n, int k);
    pins[idx] = v;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cyc++;
      if (cpu_int[k]) begin pulses++; last_pulse = cyc; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rise;
    logic [11:0] e;
    void'($urandom(32'd20250611));
    model_lo = pack6(0);
    model_hi = pack6(6);
    repeat (3) @(negedge clk);
    check("R4 outputs in reset", {20'b0, cpu_int}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    reg_sel = 1'b1; #1;
    check("R4 low map default", reg_rdata, pack6(0));
    reg_sel = 1'b0; #1;
    check("R4 high map default", reg_rdata, pack6(6));
    check("R4 outputs idle", {20'b0, cpu_int}, 32'h0);
    @(negedge clk);

    // R3: reserved bits
    reg_write(1'b1, 32'hFFFF_FFFF);
    reg_sel = 1'b1; #1;
    check("R3 reserved bits read 0", reg_rdata, mask32());
    @(negedge clk);
    reg_write(1'b1, pack6(0));

    // R1: every internal code reaches INT4
    for (int c = 0; c < 16; c++) begin
      if (c >= 4 && c < 8) continue;
      reg_write(1'b1, (pack6(0) & ~32'hF) | 32'(c));
      periph = '0;
      periph[(c < 4) ? c : c - 4] = 1'b1;
      @(negedge clk);
      periph = '0;
      check($sformatf("R1 code %0d to INT4", c), {31'b0, cpu_int[0]}, 32'h1);
    end

    // R8: write and event in the same cycle
    reg_write(1'b1, pack6(0));
    reg_we = 1'b1; reg_sel = 1'b1;
    reg_wdata = (pack6(0) & ~32'hF) | 32'd2;
    periph = 12'h001;
    @(negedge clk);
    reg_we = 1'b0; periph = '0;
    model_lo = reg_wdata & mask32();
    check("R8 same-cycle event uses old code", {31'b0, cpu_int[0]}, 32'h1);
    periph = 12'h004;
    @(negedge clk);
    check("R8 new code routes", {31'b0, cpu_int[0]}, 32'h1);
    periph = 12'h001;
    @(negedge clk);
    periph = '0;
    check("R8 old source dropped", {31'b0, cpu_int[0]}, 32'h0);

    // R9: fan-out of code 13 to several lines
    reg_write(1'b1, 32'(13) | (32'(13) << lsb_of(3)) | (32'(1) << lsb_of(1)));
    reg_write(1'b0, 32'(13) << lsb_of(5));
    periph = 12'h200;   // code 13
    e = exp_lines(src_of(12'h200));
    @(negedge clk);
    periph = '0;
    check("R9 fan-out lines", {20'b0, cpu_int}, {20'b0, e});
    check("R9 expected fan-out set", {20'b0, e}, 32'h809);

    // R6/R7/R10: pin 1 (code 5) on INT12 (line 8, high field 2)
    reg_write(1'b0, (pack6(6) & ~(32'hF << lsb_of(2))) | (32'd5 << lsb_of(2)));
    pulses = 0;
    drive_pin(1, 1'b0, 1, 8);
    drive_pin(1, 1'b1, 8, 8);
    check("R7 one-cycle low ignored", 32'(pulses), 32'd0);
    pulses = 0;
    drive_pin(1, 1'b0, 2, 8);
    rise = cyc;
    drive_pin(1, 1'b1, 10, 8);
    check("R6 valid event count", 32'(pulses), 32'd1);
    check("R6 latency from rise", 32'(last_pulse - rise), 32'd5);
    check("R10 single pulse while high", 32'(pulses), 32'd1);
    pulses = 0;
    drive_pin(1, 1'b0, 3, 8);
    drive_pin(1, 1'b1, 1, 8);
    drive_pin(1, 1'b0, 3, 8);
    check("R7 one-cycle high no event", 32'(pulses), 32'd0);
    rise = cyc;
    drive_pin(1, 1'b1, 10, 8);
    check("R7 armed low survives glitch", 32'(pulses), 32'd1);
    check("R7 latency after glitch", 32'(last_pulse - rise), 32'd5);

    // R6: each pin through its own code on INT12
    for (int i = 0; i < 4; i++) begin
      reg_write(1'b0, (pack6(6) & ~(32'hF << lsb_of(2))) | (32'(4 + i) << lsb_of(2)));
      pulses = 0;
      drive_pin(i, 1'b0, 4, 8);
      rise = cyc;
      drive_pin(i, 1'b1, 9, 8);
      check($sformatf("R6 pin %0d event", i), 32'(pulses), 32'd1);
      check($sformatf("R6 pin %0d latency", i), 32'(last_pulse - rise), 32'd5);
    end

    // random phase: R2 and R5, writes mixed with events
    for (int it = 0; it < 400; it++) begin
      logic [11:0] p;
      logic        w, s;
      logic [31:0] d;
      p = 12'($urandom) & 12'($urandom);
      w = ($urandom % 3) == 0;
      s = 1'($urandom);
      d = $urandom;
      e = exp_lines(src_of(p));
      periph = p; reg_we = w; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      if (w) begin
        if (s) model_lo = d & mask32(); else model_hi = d & mask32();
      end
      reg_we = 1'b0; periph = '0;
      check("R5 routed pulses", {20'b0, cpu_int}, {20'b0, e});
      reg_sel = 1'($urandom); #1;
      check("R2 readback", reg_rdata, reg_sel ? model_lo : model_hi);
    end
    @(negedge clk);
    check("R5 quiet after events", {20'b0, cpu_int}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule